// File: doc/BRIEF.md
# Interrupt Line Aggregator with Message Delivery

This block collects eleven device interrupt lines and turns them into one processor interrupt, delivered as a single posted write of a programmed data word to a programmed address. Each line is resynchronised to the block clock. A line raises a request only when it changes state while it is enabled. Requested lines are latched until software reads them, and that read clears them.

Software programs a target word, an enable mask and a control bit through a simple 32-bit register port. To service an interrupt it reads the latched requests. It may also read a record of changes on all lines, whatever the mask, and a live view of the synchronised line levels. The live view lets a handler notice a line that stays asserted, which gives level-triggered behaviour on shared lines.

The outgoing message uses a valid/ready handshake. Once `msg_valid` rises, it and the message fields hold until `msg_ready` is seen high at a clock edge. While a message is waiting, no second one is issued. Requests latched during the wait are folded into one later message.

Top module: `irq_msg_agg`

## Requirements
- R1: After reset the mask, request and change-record registers read 0, the control register reads 1 and `msg_valid` is low.
- R2: Only lines 0-8 and 10 are implemented, giving the read mask 0x5FF. Line 9 never appears in the request, change-record or level registers.
- R3: A request bit is set only when its line changes state while its mask bit is 1. A line that is already asserted when it becomes unmasked raises no request and no message.
- R4: Reading the request register (offset 0x00C) returns the latched requests and clears them.
- R5: The change-record register (offset 0x01C) latches every change on an implemented line, whatever the mask. Reading it clears it and leaves the request register unchanged.
- R6: The level register (offset 0x028) returns the synchronised line levels. Reading it has no side effect.
- R7: The mask register (offset 0x018) holds one enable bit per line, where 1 enables the line, and reads back what was written.
- R8: Each newly latched request causes one message. The address is the target word (offset 0x004) with its low 5 bits cleared, and the data is those low 5 bits.
- R9: `msg_valid`, `msg_addr` and `msg_data` stay stable until accepted. Any number of requests latched while a message waits produce exactly one further message.
- R10: No message is issued until the target word has been written. A request latched before that write is delivered once the write happens.
- R11: Control bit 0 (offset 0x024) enables delivery. While it is 0, requests are held back and are delivered once it is set.
- R12: Reads of unused offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 11 | Asynchronous device interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read data is valid the cycle after |
| reg_addr | input | 12 | Byte offset within the register page |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write accepted when high with valid |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The bench builds the block with its default parameters: eleven lines, implemented mask 0x5FF, two synchroniser stages and a 5-bit data field. With these values the hole at line 9 can be reached, as can the exact address/data split of the target word. Holding `msg_ready` low over several line changes exercises the merge of queued requests into one message. Random single-line toggles under random masks are checked against a bench model of the request, change-record and level registers and of the message count.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_TARGET = 12'h004;
  localparam logic [REG_AW-1:0] OFS_REQ    = 12'h00C;
  localparam logic [REG_AW-1:0] OFS_MASK   = 12'h018;
  localparam logic [REG_AW-1:0] OFS_CHG    = 12'h01C;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 12'h024;
  localparam logic [REG_AW-1:0] OFS_LEVEL  = 12'h028;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      chain[s] <= '0;
      else if (s == 0) chain[s] <= d_async;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned          WIDTH = 11,
  parameter logic [WIDTH-1:0]     IMPL  = 11'h5FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  input  logic [WIDTH-1:0] enable,
  input  logic             clr_req,
  input  logic             clr_chg,
  output logic [WIDTH-1:0] req_q,
  output logic [WIDTH-1:0] chg_q,
  output logic [WIDTH-1:0] level_q,
  output logic             new_req
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] edge_v;
  logic [WIDTH-1:0] hit_v;

  assign level_q = level_in & IMPL;
  assign edge_v  = (level_in ^ prev_q) & IMPL;
  assign hit_v   = edge_v & enable;
  assign new_req = |hit_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
      chg_q  <= '0;
    end else begin
      prev_q <= level_in;
      req_q  <= (clr_req ? '0 : req_q) | hit_v;
      chg_q  <= (clr_chg ? '0 : chg_q) | edge_v;
    end
  end
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen #(
  parameter int unsigned DATA_BITS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        new_req,
  input  logic        target_set,
  input  logic        deliver_en,
  input  logic [31:0] target_word,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [31:0] msg_addr,
  output logic [31:0] msg_data
);
  localparam logic [31:0] DATA_MASK = (32'h1 << DATA_BITS) - 32'h1;

  logic owed_q;
  logic launch;

  assign launch = !msg_valid && (owed_q || new_req) && target_set && deliver_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      owed_q    <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      if (launch) begin
        msg_valid <= 1'b1;
        owed_q    <= 1'b0;
        msg_addr  <= target_word & ~DATA_MASK;
        msg_data  <= target_word & DATA_MASK;
      end else begin
        if (msg_valid && msg_ready) msg_valid <= 1'b0;
        if (new_req) owed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned              NUM_LINES   = 11,
  parameter logic [NUM_LINES-1:0]     IMPL_MASK   = 11'h5FF,
  parameter int unsigned              SYNC_STAGES = 2,
  parameter int unsigned              DATA_BITS   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int unsigned PAD = 32 - NUM_LINES;

  logic [NUM_LINES-1:0] lvl_sync, mask_q, req_q, chg_q, level_q;
  logic [31:0]          target_q;
  logic                 target_set, ctrl_en, new_req;
  logic                 rd_req, rd_chg;

  assign rd_req = reg_rd && (reg_addr == OFS_REQ);
  assign rd_chg = reg_rd && (reg_addr == OFS_CHG);

  irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(irq_lines), .q_sync(lvl_sync)
  );

  irq_latch #(.WIDTH(NUM_LINES), .IMPL(IMPL_MASK)) u_latch (
    .clk(clk), .rst_n(rst_n), .level_in(lvl_sync), .enable(mask_q),
    .clr_req(rd_req), .clr_chg(rd_chg), .req_q(req_q), .chg_q(chg_q),
    .level_q(level_q), .new_req(new_req)
  );

  irq_msg_gen #(.DATA_BITS(DATA_BITS)) u_msg (
    .clk(clk), .rst_n(rst_n), .new_req(new_req), .target_set(target_set),
    .deliver_en(ctrl_en), .target_word(target_q), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      target_q   <= '0;
      target_set <= 1'b0;
      ctrl_en    <= 1'b1;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_TARGET: begin target_q <= reg_wdata; target_set <= 1'b1; end
        OFS_MASK:   mask_q  <= reg_wdata[NUM_LINES-1:0];
        OFS_CTRL:   ctrl_en <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        OFS_TARGET: reg_rdata <= target_q;
        OFS_REQ:    reg_rdata <= {{PAD{1'b0}}, req_q};
        OFS_MASK:   reg_rdata <= {{PAD{1'b0}}, mask_q};
        OFS_CHG:    reg_rdata <= {{PAD{1'b0}}, chg_q};
        OFS_CTRL:   reg_rdata <= {31'd0, ctrl_en};
        OFS_LEVEL:  reg_rdata <= {{PAD{1'b0}}, level_q};
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_msg_agg_chk.sv
module irq_msg_agg_chk #(
  parameter int unsigned          NUM_LINES = 11,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 11'h5FF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_rd,
  input logic [11:0]          reg_addr,
  input logic [31:0]          reg_rdata,
  input logic [NUM_LINES-1:0] req_q,
  input logic [NUM_LINES-1:0] chg_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic                 target_set,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [31:0]          msg_addr,
  input logic [31:0]          msg_data
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_no_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !target_set |-> !msg_valid);

  p_impl_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q | chg_q) & ~IMPL_MASK) == '0);

  p_masked_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(req_q)) & ~$past(mask_q)) == '0);

  p_read_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 12'h00C |=> reg_rdata[NUM_LINES-1:0] == $past(req_q));

  p_chg_keeps_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 12'h01C |=> (($past(req_q) & ~req_q) == '0));
endmodule

bind irq_msg_agg irq_msg_agg_chk #(.NUM_LINES(NUM_LINES), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .req_q(req_q), .chg_q(chg_q), .mask_q(mask_q),
  .target_set(target_set), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/sim_irq_msg_agg.sv
module sim_irq_msg_agg;
  localparam logic [10:0] IMPL = 11'h5FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq_lines = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid, msg_ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0, n_bad = 0, n_msg = 0;
  logic [10:0] m_req = '0, m_chg = '0, m_mask = '0;

  always #5 clk = ~clk;

  irq_msg_agg u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always @(posedge clk) if (rst_n && msg_valid && msg_ready) n_msg++;

  function automatic logic [31:0] exp_addr(input logic [31:0] w);
    return w & 32'hFFFF_FFE0;
  endfunction
  function automatic logic [31:0] exp_data(input logic [31:0] w);
    return w & 32'h0000_001F;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // change lines and update model; waits for sync + latch + message
  task automatic drive_lines(input logic [10:0] v);
    logic [10:0] e;
    e = (v ^ irq_lines) & IMPL;
    m_chg |= e;
    m_req |= e & m_mask;
    @(negedge clk); irq_lines = v;
    settle(7);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    settle(3);
    check("R1 valid", {31'd0, msg_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd(12'h00C, d); check("R1 req", d, 0);
    rd(12'h018, d); check("R1 mask", d, 0);
    rd(12'h01C, d); check("R1 chg", d, 0);
    rd(12'h024, d); check("R1 ctrl", d, 1);
    rd(12'h100, d); check("R12 unused", d, 0);

    // R10: request before target write is held
    wr(12'h018, 32'h7FF); m_mask = 11'h7FF;
    drive_lines(11'h001);
    check("R10 no msg before target", n_msg, 0);
    wr(12'h004, 32'hABCD_1234);
    settle(4);
    check("R10 held msg delivered", n_msg, 1);
    check("R8 addr", msg_addr, exp_addr(32'hABCD_1234));
    check("R8 data", msg_data, exp_data(32'hABCD_1234));
    rd(12'h00C, d); check("R4 req read", d, {21'd0, m_req}); m_req = '0;
    rd(12'h00C, d); check("R4 req cleared", d, 0);
    rd(12'h01C, d); check("R5 chg", d, {21'd0, m_chg}); m_chg = '0;

    // R2: line 9 ignored
    base = n_msg;
    drive_lines(irq_lines ^ 11'h200);
    check("R2 no msg line9", n_msg, base);
    rd(12'h00C, d); check("R2 req", d, 0);
    rd(12'h028, d); check("R2 level", d, {21'd0, irq_lines & IMPL});

    // R3: asserted while masked, then unmasked
    wr(12'h018, 32'h0); m_mask = '0;
    drive_lines(irq_lines | 11'h004);
    base = n_msg;
    wr(12'h018, 32'h004); m_mask = 11'h004;
    settle(6);
    check("R3 no msg on unmask", n_msg, base);
    rd(12'h00C, d); check("R3 req", d, 0);
    rd(12'h018, d); check("R7 mask rb", d, 32'h004);
    rd(12'h01C, d); check("R5 chg masked line", d, {21'd0, m_chg});
    rd(12'h00C, d); check("R5 req kept", d, 0); m_chg = '0;
    rd(12'h028, d); check("R6 level", d, {21'd0, irq_lines & IMPL});
    rd(12'h028, d); check("R6 level again", d, {21'd0, irq_lines & IMPL});

    // R9: back-pressure merge
    wr(12'h018, 32'h7FF); m_mask = 11'h7FF;
    base = n_msg;
    @(negedge clk); msg_ready = 1'b0;
    drive_lines(irq_lines ^ 11'h010);
    check("R9 valid held", {31'd0, msg_valid}, 1);
    drive_lines(irq_lines ^ 11'h020);
    drive_lines(irq_lines ^ 11'h040);
    check("R9 still waiting", n_msg, base);
    @(negedge clk); msg_ready = 1'b1;
    settle(5);
    check("R9 one merged msg", n_msg, base + 2);
    rd(12'h00C, d); m_req = '0; rd(12'h01C, d); m_chg = '0;

    // R11: delivery disable
    wr(12'h024, 32'h0);
    base = n_msg;
    drive_lines(irq_lines ^ 11'h080);
    check("R11 held", n_msg, base);
    wr(12'h024, 32'h1);
    settle(4);
    check("R11 released", n_msg, base + 1);
    rd(12'h00C, d); m_req = '0; rd(12'h01C, d); m_chg = '0;

    // random single-line toggles under random masks
    void'($urandom(32'h5EED));
    for (int i = 0; i < 40; i++) begin
      logic [10:0] nm;
      int ln;
      logic en;
      if (i % 5 == 0) begin
        nm = 11'($urandom());
        wr(12'h018, {21'd0, nm}); m_mask = nm;
      end
      ln = $urandom_range(0, 10);
      en = m_mask[ln] && IMPL[ln];
      base = n_msg;
      drive_lines(irq_lines ^ (11'h1 << ln));
      check("R8 msg count", n_msg, base + (en ? 1 : 0));
      rd(12'h028, d); check("R6 level rand", d, {21'd0, irq_lines & IMPL});
      if (i % 3 == 0) begin
        rd(12'h00C, d); check("R4 req rand", d, {21'd0, m_req}); m_req = '0;
        rd(12'h01C, d); check("R5 chg rand", d, {21'd0, m_chg}); m_chg = '0;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule